// File: doc/BRIEF.md
# Tagged Register File with Renaming

This block is a small floating-point register file for an out-of-order core in which every entry holds a producer tag next to its value. A tag of zero means the entry holds a valid value. Any other tag names the reservation station that will produce the next value for that register. At dispatch, two source reads return either a ready value or the tag of the pending producer. One rename port records the dispatching instruction's station tag against its destination register. After dispatch, the register number is no longer used. Waiting instructions track their sources by tag only.

One result bus input carries a station tag and a data word. An entry takes the broadcast data only when its stored tag equals the broadcast tag. A producer that was renamed over by a younger write therefore never updates the architectural value. No write-after-write or write-after-read stall is needed. Source reads see a matching broadcast in the same cycle, through a combinational bypass.

Top module: `tagged_regfile`

## Requirements
- R1: After reset, every register has tag 0 and value 0. Every read port shows rdy_o=1, tag_o=0 and val_o=0.
- R2: A read of a register whose tag is 0 returns rdy_o=1, tag_o=0 and that register's stored value, in the same cycle.
- R3: A read of a register whose tag is nonzero, with no matching broadcast in that cycle, returns rdy_o=0, tag_o equal to the stored tag and val_o=0.
- R4: A rename (ren_en_i=1, ren_tag_i nonzero) sets the tag of register ren_idx_i to ren_tag_i from the next clock edge on. This happens even if an older producer is still pending. A read in the rename cycle still sees the old state.
- R5: A broadcast whose tag equals a register's nonzero stored tag writes bc_data_i into that register and clears its tag to 0 at the next edge.
- R6: A broadcast whose tag differs from a register's stored tag leaves that register's tag and value unchanged. This covers an older producer that was renamed over.
- R7: If a rename targets a register in the same cycle as a broadcast matching that register, the register's tag after the edge is the new rename tag.
- R8: A read of a register whose stored tag matches the broadcast tag in the same cycle returns rdy_o=1, tag_o=0 and val_o=bc_data_i.
- R9: Tag 0 is reserved. A rename with ren_tag_i=0 is ignored, and a broadcast with bc_tag_i=0 matches no register.
- R10: The two read ports are independent and may select the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | IDX_W | Source A register number |
| rd_a_val_o | output | DATA_W | Source A value (0 when not ready) |
| rd_a_tag_o | output | TAG_W | Source A producer tag (0 when ready) |
| rd_a_rdy_o | output | 1 | Source A value valid |
| rd_b_idx_i | input | IDX_W | Source B register number |
| rd_b_val_o | output | DATA_W | Source B value (0 when not ready) |
| rd_b_tag_o | output | TAG_W | Source B producer tag (0 when ready) |
| rd_b_rdy_o | output | 1 | Source B value valid |
| ren_en_i | input | 1 | Rename request |
| ren_idx_i | input | IDX_W | Destination register to rename |
| ren_tag_i | input | TAG_W | Tag of the new producer |
| bc_en_i | input | 1 | Result broadcast valid |
| bc_tag_i | input | TAG_W | Tag of the broadcasting producer |
| bc_data_i | input | DATA_W | Broadcast result value |

## Verification
Read results are combinational, so they are due in the same cycle as their index and any bypassing broadcast. Renames and broadcast writes show up on the read ports one edge later. The bench drives every vector on the falling edge and samples the outputs shortly afterwards, before the next rising edge. The effect of each update is checked in the following vector, which is exactly one register stage later. Ignored renames and mismatched broadcasts are observed through the read ports in the cycle that follows the stimulus.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  // tag value meaning "no pending producer"
  localparam int unsigned TAG_READY = 0;
endpackage

// File: rtl/rf_entry.sv
`timescale 1ns/1ps
module rf_entry #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ren_hit_i,
  input  logic [TAG_W-1:0]  ren_tag_i,
  input  logic              bc_en_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic [DATA_W-1:0] val_o,
  output logic [TAG_W-1:0]  tag_o
);
  import rf_pkg::*;

  logic [DATA_W-1:0] val_q;
  logic [TAG_W-1:0]  tag_q;
  logic              bc_match;

  assign bc_match = bc_en_i && (tag_q != TAG_W'(TAG_READY)) && (bc_tag_i == tag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      tag_q <= TAG_W'(TAG_READY);
    end else begin
      if (bc_match) val_q <= bc_data_i;
      // rename wins over the clear
      if (ren_hit_i)     tag_q <= ren_tag_i;
      else if (bc_match) tag_q <= TAG_W'(TAG_READY);
    end
  end

  assign val_o = val_q;
  assign tag_o = tag_q;
endmodule

// File: rtl/rf_rdport.sv
`timescale 1ns/1ps
module rf_rdport #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned TAG_W    = 3,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  reg_val_i,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]   reg_tag_i,
  input  logic                             bc_en_i,
  input  logic [TAG_W-1:0]                 bc_tag_i,
  input  logic [DATA_W-1:0]                bc_data_i,
  output logic [DATA_W-1:0]                val_o,
  output logic [TAG_W-1:0]                 tag_o,
  output logic                             rdy_o
);
  import rf_pkg::*;

  logic [TAG_W-1:0]  sel_tag;
  logic [DATA_W-1:0] sel_val;
  logic              pend, byp;

  always_comb begin
    sel_tag = reg_tag_i[idx_i];
    sel_val = reg_val_i[idx_i];
    pend    = (sel_tag != TAG_W'(TAG_READY));
    byp     = pend && bc_en_i && (bc_tag_i == sel_tag);
    rdy_o   = !pend || byp;
    tag_o   = rdy_o ? TAG_W'(TAG_READY) : sel_tag;
    if (byp)       val_o = bc_data_i;
    else if (pend) val_o = '0;
    else           val_o = sel_val;
  end
endmodule

// File: rtl/tagged_regfile.sv
`timescale 1ns/1ps
module tagged_regfile #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned TAG_W    = 3,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_val_o,
  output logic [TAG_W-1:0]  rd_a_tag_o,
  output logic              rd_a_rdy_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_val_o,
  output logic [TAG_W-1:0]  rd_b_tag_o,
  output logic              rd_b_rdy_o,
  input  logic              ren_en_i,
  input  logic [IDX_W-1:0]  ren_idx_i,
  input  logic [TAG_W-1:0]  ren_tag_i,
  input  logic              bc_en_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i
);
  import rf_pkg::*;

  localparam int unsigned NUM_RD = 2;

  logic [NUM_REGS-1:0][DATA_W-1:0] reg_val;
  logic [NUM_REGS-1:0][TAG_W-1:0]  reg_tag;
  logic                            ren_ok;

  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx;
  logic [NUM_RD-1:0][DATA_W-1:0] rd_val;
  logic [NUM_RD-1:0][TAG_W-1:0]  rd_tag;
  logic [NUM_RD-1:0]             rd_rdy;

  // tag 0 is reserved, so such a rename is dropped
  assign ren_ok = ren_en_i && (ren_tag_i != TAG_W'(TAG_READY));

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_ent
    rf_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ren_hit_i (ren_ok && (ren_idx_i == IDX_W'(k))),
      .ren_tag_i (ren_tag_i),
      .bc_en_i   (bc_en_i),
      .bc_tag_i  (bc_tag_i),
      .bc_data_i (bc_data_i),
      .val_o     (reg_val[k]),
      .tag_o     (reg_tag[k])
    );
  end

  assign rd_idx[0] = rd_a_idx_i;
  assign rd_idx[1] = rd_b_idx_i;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_rdport #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_rd (
      .idx_i     (rd_idx[p]),
      .reg_val_i (reg_val),
      .reg_tag_i (reg_tag),
      .bc_en_i   (bc_en_i),
      .bc_tag_i  (bc_tag_i),
      .bc_data_i (bc_data_i),
      .val_o     (rd_val[p]),
      .tag_o     (rd_tag[p]),
      .rdy_o     (rd_rdy[p])
    );
  end

  assign rd_a_val_o = rd_val[0];
  assign rd_a_tag_o = rd_tag[0];
  assign rd_a_rdy_o = rd_rdy[0];
  assign rd_b_val_o = rd_val[1];
  assign rd_b_tag_o = rd_tag[1];
  assign rd_b_rdy_o = rd_rdy[1];
endmodule

// File: rtl/rf_checker.sv
`timescale 1ns/1ps
module rf_checker #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned TAG_W    = 3,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [IDX_W-1:0]                rd_a_idx_i,
  input logic [DATA_W-1:0]               rd_a_val_o,
  input logic [TAG_W-1:0]                rd_a_tag_o,
  input logic                            rd_a_rdy_o,
  input logic                            ren_en_i,
  input logic [IDX_W-1:0]                ren_idx_i,
  input logic [TAG_W-1:0]                ren_tag_i,
  input logic                            bc_en_i,
  input logic [TAG_W-1:0]                bc_tag_i,
  input logic [DATA_W-1:0]               bc_data_i,
  input logic [NUM_REGS-1:0][DATA_W-1:0] reg_val,
  input logic [NUM_REGS-1:0][TAG_W-1:0]  reg_tag
);
  AST_PEND_HIDES_VAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_a_rdy_o |-> (rd_a_val_o == '0) && (rd_a_tag_o != '0)); // R3

  AST_BYPASS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bc_en_i && bc_tag_i != '0 && reg_tag[rd_a_idx_i] == bc_tag_i)
    |-> rd_a_rdy_o && (rd_a_val_o == bc_data_i)); // R8

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_chk
    AST_RENAME_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ren_en_i && ren_tag_i != '0 && ren_idx_i == IDX_W'(k))
      |=> reg_tag[k] == $past(ren_tag_i)); // R4

    AST_MATCH_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bc_en_i && bc_tag_i != '0 && reg_tag[k] == bc_tag_i &&
       !(ren_en_i && ren_tag_i != '0 && ren_idx_i == IDX_W'(k)))
      |=> (reg_tag[k] == '0) && (reg_val[k] == $past(bc_data_i))); // R5

    AST_MISMATCH_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(bc_en_i && reg_tag[k] == bc_tag_i) &&
       !(ren_en_i && ren_idx_i == IDX_W'(k)))
      |=> $stable(reg_tag[k]) && $stable(reg_val[k])); // R6
  end
endmodule

bind tagged_regfile rf_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_a_idx_i (rd_a_idx_i),
  .rd_a_val_o (rd_a_val_o),
  .rd_a_tag_o (rd_a_tag_o),
  .rd_a_rdy_o (rd_a_rdy_o),
  .ren_en_i   (ren_en_i),
  .ren_idx_i  (ren_idx_i),
  .ren_tag_i  (ren_tag_i),
  .bc_en_i    (bc_en_i),
  .bc_tag_i   (bc_tag_i),
  .bc_data_i  (bc_data_i),
  .reg_val    (reg_val),
  .reg_tag    (reg_tag)
);

// File: tb/sim_tagged_regfile.sv
`timescale 1ns/1ps
module sim_tagged_regfile;
  localparam int NUM_REGS = 4;
  localparam int DATA_W   = 32;
  localparam int TAG_W    = 3;
  localparam int IDX_W    = 2;
  localparam int NVEC     = 17;

  typedef struct packed {
    logic              ren_en;
    logic [IDX_W-1:0]  ren_idx;
    logic [TAG_W-1:0]  ren_tag;
    logic              bc_en;
    logic [TAG_W-1:0]  bc_tag;
    logic [DATA_W-1:0] bc_data;
    logic [IDX_W-1:0]  ra;
    logic [IDX_W-1:0]  rb;
    logic              ea_rdy;
    logic [TAG_W-1:0]  ea_tag;
    logic [DATA_W-1:0] ea_val;
    logic              eb_rdy;
    logic [TAG_W-1:0]  eb_tag;
    logic [DATA_W-1:0] eb_val;
    logic [3:0]        req;
  } vec_t;

  // ren(en,idx,tag) bc(en,tag,data) ra rb | expA(rdy,tag,val) expB | req
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,2'd0,3'd0, 1'b0,3'd0,32'h0,     2'd0,2'd1, 1'b1,3'd0,32'h0,     1'b1,3'd0,32'h0,    4'd1},  // R1
    '{1'b1,2'd0,3'd1, 1'b0,3'd0,32'h0,     2'd0,2'd0, 1'b1,3'd0,32'h0,     1'b1,3'd0,32'h0,    4'd4},  // R4 old state seen
    '{1'b1,2'd0,3'd2, 1'b0,3'd0,32'h0,     2'd0,2'd1, 1'b0,3'd1,32'h0,     1'b1,3'd0,32'h0,    4'd3},  // R3 R4
    '{1'b0,2'd0,3'd0, 1'b1,3'd1,32'hAAAA,  2'd0,2'd1, 1'b0,3'd2,32'h0,     1'b1,3'd0,32'h0,    4'd4},  // R4 renamed over
    '{1'b0,2'd0,3'd0, 1'b0,3'd0,32'h0,     2'd0,2'd2, 1'b0,3'd2,32'h0,     1'b1,3'd0,32'h0,    4'd6},  // R6 stale bc ignored
    '{1'b0,2'd0,3'd0, 1'b1,3'd2,32'h55,    2'd0,2'd1, 1'b1,3'd0,32'h55,    1'b1,3'd0,32'h0,    4'd8},  // R8 bypass
    '{1'b0,2'd0,3'd0, 1'b0,3'd0,32'h0,     2'd0,2'd3, 1'b1,3'd0,32'h55,    1'b1,3'd0,32'h0,    4'd5},  // R5 written
    '{1'b1,2'd1,3'd3, 1'b0,3'd0,32'h0,     2'd0,2'd1, 1'b1,3'd0,32'h55,    1'b1,3'd0,32'h0,    4'd2},  // R2
    '{1'b1,2'd1,3'd4, 1'b1,3'd3,32'h77,    2'd1,2'd2, 1'b1,3'd0,32'h77,    1'b1,3'd0,32'h0,    4'd8},  // R8 with rename
    '{1'b0,2'd0,3'd0, 1'b0,3'd0,32'h0,     2'd1,2'd0, 1'b0,3'd4,32'h0,     1'b1,3'd0,32'h55,   4'd7},  // R7 new tag wins
    '{1'b1,2'd2,3'd0, 1'b1,3'd0,32'h99,    2'd2,2'd2, 1'b1,3'd0,32'h0,     1'b1,3'd0,32'h0,    4'd9},  // R9
    '{1'b0,2'd0,3'd0, 1'b0,3'd0,32'h0,     2'd2,2'd1, 1'b1,3'd0,32'h0,     1'b0,3'd4,32'h0,    4'd9},  // R9 tag-0 ignored
    '{1'b0,2'd0,3'd0, 1'b1,3'd4,32'h1234,  2'd3,2'd3, 1'b1,3'd0,32'h0,     1'b1,3'd0,32'h0,    4'd10}, // R10
    '{1'b0,2'd0,3'd0, 1'b0,3'd0,32'h0,     2'd1,2'd0, 1'b1,3'd0,32'h1234,  1'b1,3'd0,32'h55,   4'd5},  // R5
    '{1'b1,2'd3,3'd5, 1'b0,3'd0,32'h0,     2'd3,2'd3, 1'b1,3'd0,32'h0,     1'b1,3'd0,32'h0,    4'd10}, // R10
    '{1'b1,2'd3,3'd6, 1'b1,3'd5,32'hCAFE,  2'd3,2'd1, 1'b1,3'd0,32'hCAFE,  1'b1,3'd0,32'h1234, 4'd7},  // R7 R8
    '{1'b0,2'd0,3'd0, 1'b0,3'd0,32'h0,     2'd3,2'd3, 1'b0,3'd6,32'h0,     1'b0,3'd6,32'h0,    4'd7}   // R7 R10
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [IDX_W-1:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, ren_idx_i = '0;
  logic [DATA_W-1:0] rd_a_val_o, rd_b_val_o, bc_data_i = '0;
  logic [TAG_W-1:0]  rd_a_tag_o, rd_b_tag_o, ren_tag_i = '0, bc_tag_i = '0;
  logic              rd_a_rdy_o, rd_b_rdy_o, ren_en_i = 1'b0, bc_en_i = 1'b0;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tagged_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_a_idx_i(rd_a_idx_i), .rd_a_val_o(rd_a_val_o), .rd_a_tag_o(rd_a_tag_o), .rd_a_rdy_o(rd_a_rdy_o),
    .rd_b_idx_i(rd_b_idx_i), .rd_b_val_o(rd_b_val_o), .rd_b_tag_o(rd_b_tag_o), .rd_b_rdy_o(rd_b_rdy_o),
    .ren_en_i(ren_en_i), .ren_idx_i(ren_idx_i), .ren_tag_i(ren_tag_i),
    .bc_en_i(bc_en_i), .bc_tag_i(bc_tag_i), .bc_data_i(bc_data_i)
  );

  task automatic chk(input string req, input string what,
                     input logic [DATA_W+TAG_W:0] act, input logic [DATA_W+TAG_W:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #40000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      ren_en_i  = VECS[i].ren_en;  ren_idx_i = VECS[i].ren_idx; ren_tag_i = VECS[i].ren_tag;
      bc_en_i   = VECS[i].bc_en;   bc_tag_i  = VECS[i].bc_tag;  bc_data_i = VECS[i].bc_data;
      rd_a_idx_i = VECS[i].ra;     rd_b_idx_i = VECS[i].rb;
      #1;
      chk($sformatf("R%0d v%0d", VECS[i].req, i), "port a",
          {rd_a_rdy_o, rd_a_tag_o, rd_a_val_o}, {VECS[i].ea_rdy, VECS[i].ea_tag, VECS[i].ea_val});
      chk($sformatf("R%0d v%0d", VECS[i].req, i), "port b",
          {rd_b_rdy_o, rd_b_tag_o, rd_b_val_o}, {VECS[i].eb_rdy, VECS[i].eb_tag, VECS[i].eb_val});
    end
    // R1: reset mid-run clears pending tags and values
    @(negedge clk);
    ren_en_i = 1'b0; bc_en_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    for (int r = 0; r < NUM_REGS; r++) begin
      rd_a_idx_i = IDX_W'(r);
      rd_b_idx_i = IDX_W'(NUM_REGS - 1 - r);
      #1;
      chk("R1", "port a after reset", {rd_a_rdy_o, rd_a_tag_o, rd_a_val_o}, {1'b1, 3'd0, 32'h0});
      chk("R1", "port b after reset", {rd_b_rdy_o, rd_b_tag_o, rd_b_val_o}, {1'b1, 3'd0, 32'h0});
    end
    @(negedge clk);
    rst_ni = 1'b1;
    // R9: broadcast with tag 0 changes no ready register
    @(negedge clk);
    bc_en_i = 1'b1; bc_tag_i = '0; bc_data_i = 32'hDEAD;
    rd_a_idx_i = 2'd2;
    @(negedge clk);
    bc_en_i = 1'b0;
    #1;
    chk("R9", "tag-0 broadcast", {rd_a_rdy_o, rd_a_tag_o, rd_a_val_o}, {1'b1, 3'd0, 32'h0});
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule